// File: doc/BRIEF.md
# Zero-Crossing Quality Indicator

This block judges how well a received baseband signal is behaving by looking at the timing of its zero-crossings. The bit-clock recovery loop predicts when each crossing should arrive. On each crossing strobe the block compares the measured crossing phase with that prediction and grades the crossing GOOD or BAD. Phase is given in 1/64-bit units. The comparison uses the shortest distance around the bit period, so a crossing just before the bit boundary and a prediction just after it count as close.

The single-bit quality output is high only through an unbroken run of GOOD crossings, and any BAD crossing pulls it low. After a BAD crossing, a programmable number of consecutive GOOD crossings is needed before the output goes high again. When the receive path is put into power saving, the output is held at 0. A noisier signal produces more BAD crossings and so less high time.

An averaging section, which can be left out at build time, turns the high time into a number. It counts the bit ticks on which the output was high over a window of 2^K ticks and latches that count at the end of each window.

Top module: `zc_quality_top`

## Requirements
- R1: After reset the quality output is 0, the latched average count is 0 and the window-done pulse is 0.
- R2: A crossing is GOOD when the magnitude of its phase error is at most the tolerance input, and BAD otherwise. The phase error is (crossing phase − expected phase) modulo 64, read as a signed value from −32 to +31. The magnitude of −32 is 32. Both phases are in 1/64-bit units.
- R3: A BAD crossing sampled at a clock edge drives the quality output to 0 from that edge on and clears the run of GOOD crossings.
- R4: After reset, a BAD crossing or power saving, the quality output goes to 1 at the edge that samples the Nth consecutive GOOD crossing, where N is the run-length input in the range 1 to 15. A value of 0 behaves like 1. Further GOOD crossings keep the output at 1.
- R5: A cycle with no crossing strobe leaves the quality output and the current run of GOOD crossings unchanged.
- R6: While power saving is sampled high, the quality output is 0 from the next edge on and crossing strobes have no effect. Once power saving is released, a fresh run of N GOOD crossings is needed before the output returns to 1.
- R7: The averaging count adds 1 for each sampled bit tick on which the quality output is 1. The window is 2^K ticks counted from reset. At the edge that samples the last tick of a window, the total is latched into the average count output and the running total restarts at 0.
- R8: The window-done output is high for exactly the one cycle after each window's last tick, and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_psave_i | input | 1 | Receive power saving; forces quality low |
| zc_strobe_i | input | 1 | One-cycle strobe marking a detected zero-crossing |
| zc_phase_i | input | PH_W (6) | Measured crossing phase, 1/64-bit units |
| exp_phase_i | input | PH_W (6) | Crossing phase predicted by the clock recovery loop |
| tol_i | input | PH_W (6) | Largest phase error magnitude still graded GOOD |
| run_len_i | input | RUN_W (4) | GOOD crossings needed to raise the output |
| bit_tick_i | input | 1 | One-cycle pulse per received bit, paces the averager |
| quality_o | output | 1 | Quality indication, high through runs of GOOD crossings |
| avg_count_o | output | AVG_LOG2+1 (5) | Count of high ticks in the last finished window |
| avg_valid_o | output | 1 | One-cycle pulse when avg_count_o is refreshed |

## Verification
The assertions assume that the tolerance and run-length inputs are held steady while a run of crossings is being graded, and that the bit tick arrives at most once per cycle. The stimulus changes these settings only between runs, with a BAD crossing or a reset in between, so each run starts from a known state. Every input is driven on the falling clock edge, which keeps strobe and tick from changing at the sampling edge. Phase values always stay inside the 64-unit bit period.

// File: rtl/zcq_pkg.sv
package zcq_pkg;
    // Run tracker state
    typedef struct packed {
        logic [3:0] run;
        logic       qual;
    } zcq_run_t;

    // Run-length width shared by tracker and top
    localparam int unsigned RUN_W = 4;
endpackage

// File: rtl/zcq_phase_grader.sv
module zcq_phase_grader #(
    parameter int unsigned PH_W = 6
) (
    input  logic [PH_W-1:0] zc_phase_i,
    input  logic [PH_W-1:0] exp_phase_i,
    input  logic [PH_W-1:0] tol_i,
    output logic            good_o
);
    logic [PH_W-1:0] diff;
    logic [PH_W-1:0] mag;

    always_comb begin
        diff = zc_phase_i - exp_phase_i;
        // shortest distance around the bit period
        if (diff[PH_W-1]) begin
            mag = (~diff) + 1'b1;
        end else begin
            mag = diff;
        end
        good_o = (mag <= tol_i);
    end
endmodule

// File: rtl/zcq_run_tracker.sv
module zcq_run_tracker
    import zcq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psave_i,
    input  logic             strobe_i,
    input  logic             good_i,
    input  logic [RUN_W-1:0] run_len_i,
    output logic             quality_o
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    zcq_run_t st_d, st_q;
    logic [RUN_W-1:0] run_inc;

    always_comb begin
        st_d    = st_q;
        run_inc = (st_q.run == RUN_MAX) ? st_q.run : st_q.run + 1'b1;
        if (psave_i) begin
            st_d.run  = '0;
            st_d.qual = 1'b0;
        end else if (strobe_i) begin
            if (good_i) begin
                st_d.run  = run_inc;
                st_d.qual = (run_inc >= run_len_i);
            end else begin
                st_d.run  = '0;
                st_d.qual = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign quality_o = st_q.qual;

    // R3: a bad crossing pulls the output low at once
    assert_bad_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && !good_i) |=> !quality_o);

    // R6: power saving forces the output low
    assert_psave_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        psave_i |=> !quality_o);

    // R4: the output can only rise on a good crossing
    assert_rise_on_good_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!quality_o && !(strobe_i && good_i)) |=> !quality_o);

    // R5: no strobe, no change
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_i && !psave_i) |=> ($stable(quality_o) && $stable(st_q.run)));
endmodule

// File: rtl/zcq_high_averager.sv
module zcq_high_averager #(
    parameter int unsigned AVG_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              high_i,
    output logic [AVG_LOG2:0] count_o,
    output logic              valid_o
);
    localparam int unsigned CW = AVG_LOG2 + 1;
    localparam logic [AVG_LOG2-1:0] LAST_TICK = '1;
    localparam logic [CW-1:0] WIN = CW'(1) << AVG_LOG2;

    typedef struct packed {
        logic [AVG_LOG2-1:0] ticks;
        logic [CW-1:0]       acc;
        logic [CW-1:0]       count;
        logic                valid;
    } avg_st_t;

    avg_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (tick_i) begin
            st_d.ticks = st_q.ticks + 1'b1;
            if (st_q.ticks == LAST_TICK) begin
                st_d.count = st_q.acc + CW'(high_i);
                st_d.acc   = '0;
                st_d.valid = 1'b1;
            end else begin
                st_d.acc = st_q.acc + CW'(high_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign valid_o = st_q.valid;

    // R7: a window never holds more high ticks than its length
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (count_o <= WIN));

    // R8: window-done is a single-cycle pulse
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8: window-done only follows a sampled tick
    assert_valid_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> !valid_o);
endmodule

// File: rtl/zc_quality_top.sv
module zc_quality_top
    import zcq_pkg::*;
#(
    parameter int unsigned PH_W     = 6,
    parameter int unsigned AVG_LOG2 = 4,
    parameter bit          AVG_EN   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_psave_i,
    input  logic              zc_strobe_i,
    input  logic [PH_W-1:0]   zc_phase_i,
    input  logic [PH_W-1:0]   exp_phase_i,
    input  logic [PH_W-1:0]   tol_i,
    input  logic [RUN_W-1:0]  run_len_i,
    input  logic              bit_tick_i,
    output logic              quality_o,
    output logic [AVG_LOG2:0] avg_count_o,
    output logic              avg_valid_o
);
    logic good;

    zcq_phase_grader #(.PH_W(PH_W)) grader_i (
        .zc_phase_i  (zc_phase_i),
        .exp_phase_i (exp_phase_i),
        .tol_i       (tol_i),
        .good_o      (good)
    );

    zcq_run_tracker tracker_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .psave_i   (rx_psave_i),
        .strobe_i  (zc_strobe_i),
        .good_i    (good),
        .run_len_i (run_len_i),
        .quality_o (quality_o)
    );

    generate
        if (AVG_EN) begin : g_avg
            zcq_high_averager #(.AVG_LOG2(AVG_LOG2)) avg_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick_i  (bit_tick_i),
                .high_i  (quality_o),
                .count_o (avg_count_o),
                .valid_o (avg_valid_o)
            );
        end else begin : g_no_avg
            assign avg_count_o = '0;
            assign avg_valid_o = 1'b0;
        end
    endgenerate
endmodule

// File: tb/zc_quality_top_tb_top.sv
module zc_quality_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_psave_i = 1'b0;
    logic       zc_strobe_i = 1'b0;
    logic [5:0] zc_phase_i = '0;
    logic [5:0] exp_phase_i = '0;
    logic [5:0] tol_i = 6'd8;
    logic [3:0] run_len_i = 4'd4;
    logic       bit_tick_i = 1'b0;
    logic       quality_o;
    logic [4:0] avg_count_o;
    logic       avg_valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    zc_quality_top dut_i (
        .clk (clk), .rst_n (rst_n), .rx_psave_i (rx_psave_i),
        .zc_strobe_i (zc_strobe_i), .zc_phase_i (zc_phase_i),
        .exp_phase_i (exp_phase_i), .tol_i (tol_i), .run_len_i (run_len_i),
        .bit_tick_i (bit_tick_i), .quality_o (quality_o),
        .avg_count_o (avg_count_o), .avg_valid_o (avg_valid_o)
    );

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one crossing, result visible on return
    task automatic xing(input int zc, input int ex);
        zc_strobe_i = 1'b1;
        zc_phase_i  = 6'(zc);
        exp_phase_i = 6'(ex);
        @(negedge clk);
        zc_strobe_i = 1'b0;
    endtask

    function automatic int exp_good(input int zc, input int ex, input int tol);
        int d;
        int m;
        d = ((zc - ex) % 64 + 64) % 64;
        m = (d >= 32) ? 64 - d : d;
        return (m <= tol) ? 1 : 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int tols [4] = '{0, 3, 8, 31};
        int exps [3] = '{0, 17, 63};
        int acc;
        int nt;
        int q;
        do_reset();
        // R1
        check_val("R1 quality", int'(quality_o), 0);
        check_val("R1 count", int'(avg_count_o), 0);
        check_val("R1 valid", int'(avg_valid_o), 0);

        // R2: sweep every crossing phase with run length 1
        run_len_i = 4'd1;
        foreach (tols[t]) begin
            tol_i = 6'(tols[t]);
            foreach (exps[e]) begin
                for (int zc = 0; zc < 64; zc++) begin
                    xing(zc, exps[e]);
                    check_val("R2 grade", int'(quality_o), exp_good(zc, exps[e], tols[t]));
                end
            end
        end

        // R4: run lengths 0..6
        tol_i = 6'd8;
        for (int n = 0; n <= 6; n++) begin
            run_len_i = 4'(n);
            xing(32, 0);
            check_val("R3 bad low", int'(quality_o), 0);
            for (int g = 1; g <= n + 2; g++) begin
                xing(g, 0);
                check_val("R4 run", int'(quality_o), (g >= ((n == 0) ? 1 : n)) ? 1 : 0);
            end
        end

        // R5: idle cycles hold high, then hold low after a bad crossing
        repeat (5) begin
            @(negedge clk);
            check_val("R5 hold high", int'(quality_o), 1);
        end
        run_len_i = 4'd3;
        xing(0, 0);
        xing(0, 0);
        xing(40, 0);
        check_val("R3 bad from high", int'(quality_o), 0);
        xing(0, 0);
        xing(0, 0);
        repeat (4) begin
            @(negedge clk);
            check_val("R5 hold low", int'(quality_o), 0);
        end
        xing(0, 0);
        check_val("R5 run kept across idle", int'(quality_o), 1);

        // R6: power saving
        rx_psave_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            xing(0, 0);
            check_val("R6 psave low", int'(quality_o), 0);
        end
        rx_psave_i = 1'b0;
        xing(0, 0);
        check_val("R6 fresh run 1", int'(quality_o), 0);
        xing(0, 0);
        check_val("R6 fresh run 2", int'(quality_o), 0);
        xing(0, 0);
        check_val("R6 fresh run 3", int'(quality_o), 1);

        // R7 / R8: averaging with two tick rates
        for (int div = 1; div <= 3; div += 2) begin
            do_reset();
            run_len_i = 4'd2;
            tol_i = 6'd8;
            acc = 0;
            nt = 0;
            for (int i = 0; i < 48 * div; i++) begin
                q = int'(quality_o);
                bit_tick_i  = (i % div == 0);
                zc_strobe_i = (i % 3 != 2);
                zc_phase_i  = (i % 7 == 0) ? 6'd32 : 6'd1;
                exp_phase_i = 6'd0;
                @(negedge clk);
                if (bit_tick_i) begin
                    nt++;
                    acc += q;
                    if (nt % 16 == 0) begin
                        check_val("R8 window done", int'(avg_valid_o), 1);
                        check_val("R7 count", int'(avg_count_o), acc);
                        acc = 0;
                    end else if (avg_valid_o) begin
                        check_val("R8 stray pulse", 1, 0);
                    end
                end else if (avg_valid_o) begin
                    check_val("R8 stray pulse", 1, 0);
                end
            end
            bit_tick_i  = 1'b0;
            zc_strobe_i = 1'b0;
            @(negedge clk);
            check_val("R8 pulse ends", int'(avg_valid_o), 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule